// File: doc/BRIEF.md
# Interrupt Control and Status Register

This block is the 8-bit interrupt control and status register of a small microcontroller core. It watches three event sources: a one-cycle timer wrap pulse, a synchronised external request pin, and a 6-pin general-purpose port. Each source has a sticky flag in the register. A flag is latched whenever its event happens, whatever the state of the enable bits. Software clears a flag by writing the register with that bit at 0. A separate 6-bit mask, supplied from outside, selects which port pins can raise the port-change flag.

The single interrupt request output has two levels of gating. The top enable bit masks everything. The peripheral enable bit masks the aggregated request that arrives from other peripherals. Below the two gates, each local flag counts only when its own enable bit is set. There is no data stream: the write strobe and the read value are plain register-access pins. A write takes effect on the next clock edge, and the read value always shows the current register contents.

Top module: `irq_ctrl_reg`

## Requirements
- R1: While reset is asserted, and directly after it is released, `rd_data` is 0x00 and `irq` is 0.
- R2: With `wr_en` high at a clock edge, all eight bits take the value of `wr_data`, unless an event sets a flag bit in that same cycle. Bit map from bit 7 down to bit 0: global enable, peripheral enable, timer enable, pin enable, port enable, timer flag, pin flag, port flag.
- R3: A high `tmr_wrap` at a clock edge sets bit 2 after that edge, whatever the enable bits hold.
- R4: A 0-to-1 transition of `ext_pin` between two consecutive clock samples sets bit 1. A falling edge or a steady level leaves bit 1 unchanged.
- R5: Bit 0 is set when a port pin whose `port_chg_mask` bit is 1 differs from its value at the previous clock edge, in either direction. Changes on pins whose mask bit is 0 have no effect.
- R6: Hardware never clears a flag. Without a write, a set flag stays set, and bits 7..3 keep their value.
- R7: When an event occurs at the same edge as a write of 0 to its flag, the flag ends up set.
- R8: `irq` = bit7 AND ((bit5 AND bit2) OR (bit4 AND bit1) OR (bit3 AND bit0) OR (bit6 AND `periph_req`)). With bit 7 at 0, `irq` is 0.
- R9: `periph_req` affects `irq` only while bit 6 and bit 7 are both 1.
- R10: At the first clock edge after reset, the pin and port detectors take their first sample without reporting an edge or a change, so pin levels held through reset raise no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Current register contents |
| tmr_wrap | input | 1 | One-cycle timer wrap pulse |
| ext_pin | input | 1 | Synchronised external request pin |
| port_pins | input | 6 | Synchronised port pin levels |
| port_chg_mask | input | 6 | Per-pin change enables |
| periph_req | input | 1 | Aggregated peripheral request |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a collision: an event arriving at the very edge where software writes its flag to 0. A plain register test never lines the two up, and the result would then hide whether the write or the event wins. Directed steps put a timer pulse on the same edge as a clearing write. The random phase drives writes on about a quarter of cycles while toggling the pin and port inputs freely, so collisions on all three flags happen many times. It also exercises the first-sample rule with pins held high through reset, and the mask with changes on unmasked pins only.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef struct packed {
    logic glb_en;
    logic per_en;
    logic tmr_en;
    logic pin_en;
    logic port_en;
    logic tmr_flag;
    logic pin_flag;
    logic port_flag;
  } icr_t;

  localparam int unsigned ICR_W = $bits(icr_t);
endpackage

// File: rtl/irq_event_detect.sv
module irq_event_detect #(
  parameter int unsigned PORT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_wrap,
  input  logic              ext_pin,
  input  logic [PORT_W-1:0] port_pins,
  input  logic [PORT_W-1:0] port_chg_mask,
  output logic              ev_tmr,
  output logic              ev_pin,
  output logic              ev_port
);
  logic              primed_q;
  logic              ext_q;
  logic [PORT_W-1:0] port_q;
  logic [PORT_W-1:0] diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q <= 1'b0;
      ext_q    <= 1'b0;
      port_q   <= '0;
    end else begin
      primed_q <= 1'b1;
      ext_q    <= ext_pin;
      port_q   <= port_pins;
    end
  end

  genvar g;
  generate
    for (g = 0; g < PORT_W; g++) begin : g_pin
      assign diff[g] = (port_pins[g] ^ port_q[g]) & port_chg_mask[g];
    end
  endgenerate

  assign ev_tmr  = tmr_wrap;
  assign ev_pin  = primed_q & ext_pin & ~ext_q;
  assign ev_port = primed_q & (|diff);

  // R10: directly after reset no edge or change is reported
  a_r10_first_sample: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(primed_q) |-> $past(!ev_pin && !ev_port));
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ICR_W-1:0] wr_data,
  input  logic             ev_tmr,
  input  logic             ev_pin,
  input  logic             ev_port,
  output icr_t             icr
);
  icr_t base;
  icr_t nxt;

  always_comb begin
    base = wr_en ? icr_t'(wr_data) : icr;
    nxt  = base;
    nxt.tmr_flag  = base.tmr_flag  | ev_tmr;
    nxt.pin_flag  = base.pin_flag  | ev_pin;
    nxt.port_flag = base.port_flag | ev_port;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) icr <= '0;
    else        icr <= nxt;
  end

  // R3/R7: timer event always leaves its flag set
  a_r3_tmr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tmr |=> icr.tmr_flag);
  // R4
  a_r4_pin_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pin |=> icr.pin_flag);
  // R5
  a_r5_port_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_port |=> icr.port_flag);
  // R6: no write means no bit is lost and enables hold
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((icr[2:0] & $past(icr[2:0])) == $past(icr[2:0])) && $stable(icr[7:3]));
  // R2: quiet write loads the value
  a_r2_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ev_tmr && !ev_pin && !ev_port) |=> icr == $past(wr_data));
endmodule

// File: rtl/irq_request_gate.sv
module irq_request_gate
  import irq_ctrl_pkg::*;
(
  input  icr_t icr,
  input  logic periph_req,
  output logic irq
);
  logic local_any;
  logic periph_ok;

  always_comb begin
    local_any = (icr.tmr_en & icr.tmr_flag) | (icr.pin_en & icr.pin_flag)
              | (icr.port_en & icr.port_flag);
    periph_ok = icr.per_en & periph_req;
    irq       = icr.glb_en & (local_any | periph_ok);
  end
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned PORT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              tmr_wrap,
  input  logic              ext_pin,
  input  logic [PORT_W-1:0] port_pins,
  input  logic [PORT_W-1:0] port_chg_mask,
  input  logic              periph_req,
  output logic              irq
);
  logic ev_tmr, ev_pin, ev_port;
  icr_t icr;

  irq_event_detect #(.PORT_W(PORT_W)) u_detect (
    .clk(clk), .rst_n(rst_n), .tmr_wrap(tmr_wrap), .ext_pin(ext_pin),
    .port_pins(port_pins), .port_chg_mask(port_chg_mask),
    .ev_tmr(ev_tmr), .ev_pin(ev_pin), .ev_port(ev_port)
  );

  irq_flag_bank u_flags (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ev_tmr(ev_tmr), .ev_pin(ev_pin), .ev_port(ev_port), .icr(icr)
  );

  irq_request_gate u_gate (
    .icr(icr), .periph_req(periph_req), .irq(irq)
  );

  assign rd_data = icr;

  // R8: global enable off keeps the request low
  a_r8_global_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[7] |-> !irq);
  // R9: peripheral masked and no local source leaves request low
  a_r9_periph_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[6] && ((rd_data[5:3] & rd_data[2:0]) == 3'b000)) |-> !irq);
endmodule

// File: tb/irq_ctrl_reg_bench.sv
`timescale 1ns/1ps
module irq_ctrl_reg_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic tmr_wrap = 1'b0;
  logic ext_pin = 1'b0;
  logic [5:0] port_pins = '0;
  logic [5:0] port_chg_mask = '0;
  logic periph_req = 1'b0;
  logic irq;

  int errors = 0;
  int checks = 0;

  logic [7:0] m_reg = '0;
  logic m_ext = 1'b0;
  logic [5:0] m_port = '0;
  logic m_prim = 1'b0;

  always #5 clk = ~clk;

  irq_ctrl_reg u_irq_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .tmr_wrap(tmr_wrap), .ext_pin(ext_pin), .port_pins(port_pins),
    .port_chg_mask(port_chg_mask), .periph_req(periph_req), .irq(irq)
  );

  function automatic logic exp_irq(input logic [7:0] r, input logic pr);
    return r[7] & ((r[5] & r[2]) | (r[4] & r[1]) | (r[3] & r[0]) | (r[6] & pr));
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // drive at negedge, one clock, compare at next negedge
  task automatic step(input logic w, input logic [7:0] wd, input logic t, input logic e,
                      input logic [5:0] p, input logic [5:0] ce, input logic pr,
                      input string tag);
    logic [7:0] nx;
    wr_en = w; wr_data = wd; tmr_wrap = t; ext_pin = e;
    port_pins = p; port_chg_mask = ce; periph_req = pr;
    nx = w ? wd : m_reg;
    if (t) nx[2] = 1'b1;
    if (m_prim && e && !m_ext) nx[1] = 1'b1;
    if (m_prim && (|((p ^ m_port) & ce))) nx[0] = 1'b1;
    m_reg = nx; m_ext = e; m_port = p; m_prim = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(tag, rd_data, m_reg);
    check("R8 irq", {7'b0, irq}, {7'b0, exp_irq(m_reg, pr)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1CE5));
    // pins high through reset for R10
    ext_pin = 1'b1; port_pins = 6'h3F; port_chg_mask = 6'h3F;
    repeat (3) @(negedge clk);
    check("R1 reset rd", rd_data, 8'h00);
    check("R1 reset irq", {7'b0, irq}, 8'h00);
    rst_n = 1'b1;
    check("R1 post rd", rd_data, 8'h00);
    step(0, 8'h00, 0, 1, 6'h3F, 6'h3F, 0, "R10");
    step(0, 8'h00, 0, 1, 6'h3F, 6'h3F, 0, "R10");
    step(1, 8'h00, 0, 1, 6'h3F, 6'h3F, 0, "R2");
    step(0, 8'h00, 1, 1, 6'h3F, 6'h3F, 0, "R3");
    step(1, 8'hF8, 0, 1, 6'h3F, 6'h3F, 0, "R2");
    step(0, 8'h00, 0, 0, 6'h3F, 6'h3F, 0, "R4 fall");
    step(0, 8'h00, 0, 0, 6'h3F, 6'h3F, 0, "R4 steady");
    step(0, 8'h00, 0, 1, 6'h3F, 6'h3F, 0, "R4 rise");
    check("R4 irq", {7'b0, irq}, 8'h01);
    step(1, 8'h7A, 0, 1, 6'h3F, 6'h3F, 0, "R8 global off");
    check("R8 irq low", {7'b0, irq}, 8'h00);
    step(1, 8'h00, 0, 1, 6'h3F, 6'h3E, 0, "R2");
    step(0, 8'h00, 0, 1, 6'h3E, 6'h3E, 0, "R5 masked");
    step(0, 8'h00, 0, 1, 6'h3C, 6'h3E, 0, "R5 enabled");
    step(1, 8'h00, 1, 1, 6'h3C, 6'h3E, 0, "R7 collide");
    check("R7 flag", rd_data, 8'h04);
    step(0, 8'h00, 0, 1, 6'h3C, 6'h3E, 0, "R6 hold");
    step(0, 8'h00, 0, 1, 6'h3C, 6'h3E, 0, "R6 hold");
    step(1, 8'h40, 0, 1, 6'h3C, 6'h3E, 1, "R9 glb off");
    step(1, 8'hC0, 0, 1, 6'h3C, 6'h3E, 1, "R9 both on");
    check("R9 irq high", {7'b0, irq}, 8'h01);
    step(1, 8'h80, 0, 1, 6'h3C, 6'h3E, 1, "R9 per off");
    check("R9 irq low", {7'b0, irq}, 8'h00);
    for (int i = 0; i < 3000; i++) begin
      logic w;
      w = ($urandom % 4) == 0;
      step(w, 8'($urandom), ($urandom % 8) == 0, 1'($urandom), 6'($urandom),
           6'($urandom), 1'($urandom), w ? "R7 rand" : "R6 rand");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule